// File: doc/BRIEF.md
# Stack Bytecode Execution Core

This block runs a small integer bytecode on a hardware operand stack. It reads one byte per cycle from an instruction memory through a combinational read port. It decodes opcodes with no operands or with one or two immediate bytes, and it executes each instruction when the instruction's last byte arrives. Every operand comes from the top of the stack. Results go back onto the stack or into a small file of local variables.

Execution starts at address zero after a synchronous reset. It continues until a halt opcode stops it or a fault stops it. A fault is an unknown opcode, a push onto a full stack, or a pop from a stack with too few entries. Instructions of one, two and three bytes take one, two and three cycles. The program counter, the current top of stack and two sticky status flags are visible at the ports, so a host can observe the outcome of a program.

Top module: `stack_bc_core`

## Requirements
- R1: While reset is asserted at a clock edge, the core clears the program counter to 0, empties the stack (the top-of-stack output reads 0), clears the locals to 0, and clears both the halted and fault flags.
- R2: Opcodes 0x10 through 0x16 push the constants -1, 0, 1, 2, 3, 4 and 5 respectively. Each takes one byte and one cycle.
- R3: Opcode 0x20+n pushes local n. Opcode 0x28+n pops the top of stack into local n. There are 8 locals, indexed 0 to 7, and each reads 0 until it is written.
- R4: Opcode 0x30 with one following byte pushes that byte sign-extended to 32 bits. Opcode 0x31 with two following bytes, high byte first, pushes that 16-bit value sign-extended to 32 bits.
- R5: Opcodes 0x40 (add), 0x41 (subtract) and 0x43 (multiply) pop the top entry as a, then pop the entry below it as b, and push the low 32 bits of b op a. Subtract therefore yields the deeper entry minus the top entry.
- R6: Opcode 0x42 replaces the top entry with its two's complement negation.
- R7: Opcodes 0x50 to 0x55 are conditional branches, followed by a 16-bit offset sent high byte first. Each pops a (the top entry) and then b, and compares b with a as signed values using eq, ne, lt, gt, le and ge in that opcode order. If the test holds, the PC becomes the branch opcode's address plus the offset. Otherwise the PC advances by 3.
- R8: Opcode 0x58 is followed by a 16-bit offset, high byte first. It sets the PC to its own address plus the offset.
- R9: A push while all 16 entries are in use sets fault and halted. The PC stays on the offending opcode and the stack is left unchanged.
- R10: An instruction that needs more entries than the stack holds sets fault and halted. The PC and the stack are left unchanged.
- R11: Any opcode not listed above sets fault and halted, and the PC stays on that opcode.
- R12: Opcode 0x01 sets halted without setting fault. The PC stays on the halt opcode.
- R13: Once halted, the core holds its PC, its stack and both flags until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 10 | Byte address being fetched |
| imem_data | input | 8 | Byte at imem_addr, valid in the same cycle |
| pc | output | 10 | Address of the current instruction's opcode |
| tos | output | 32 | Top stack entry, 0 when the stack is empty |
| halted | output | 1 | Execution has stopped |
| fault | output | 1 | Execution stopped on an error |

## Verification
The embedded properties assume that reset is asserted before the first fetch. They also assume that imem_data carries a defined byte in every cycle the core is running, because the decode and the stack checks follow it combinationally. The bench meets both conditions. It fills the entire instruction memory with the halt opcode before it loads each program, and it holds reset over several edges before it releases the core. Every program therefore ends on a defined byte, even when a branch goes the wrong way.

// File: rtl/stack_bc_core.sv
module stack_bc_core #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int NLOC  = 8,
  parameter int PCW   = 10
) (
  input  logic           clk,
  input  logic           rst,
  output logic [PCW-1:0] imem_addr,
  input  logic [7:0]     imem_data,
  output logic [PCW-1:0] pc,
  output logic [W-1:0]   tos,
  output logic           halted,
  output logic           fault
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  typedef enum logic [1:0] {S_OP, S_B1, S_B2} st_t;

  st_t            st;
  logic [7:0]     op_q, hi_q;
  logic [SPW-1:0] sp;
  logic [W-1:0]   stk [DEPTH];
  logic [W-1:0]   loc [NLOC];

  logic [7:0]  op;
  logic [15:0] imm16;
  logic [IW-1:0] tidx, nidx, pidx;
  logic [W-1:0] a, b, push_val, alu_res;
  logic is_pushc, is_load, is_store, is_pb, is_ps, is_alu2, is_neg;
  logic is_br, is_jmp, is_halt, legal, pushes, taken, exec_now;
  logic under, over, bad;
  logic [1:0] len, need;

  assign op    = (st == S_OP) ? imem_data : op_q;
  assign imm16 = {hi_q, imem_data};
  assign tidx  = IW'(sp - SPW'(1));
  assign nidx  = IW'(sp - SPW'(2));
  assign pidx  = IW'(sp);
  assign a     = stk[tidx];
  assign b     = stk[nidx];

  assign is_pushc = (op[7:3] == 5'b00010) && (op[2:0] != 3'd7);
  assign is_load  = (op[7:3] == 5'b00100) && (32'(op[2:0]) < NLOC);
  assign is_store = (op[7:3] == 5'b00101) && (32'(op[2:0]) < NLOC);
  assign is_pb    = (op == 8'h30);
  assign is_ps    = (op == 8'h31);
  assign is_alu2  = (op == 8'h40) || (op == 8'h41) || (op == 8'h43);
  assign is_neg   = (op == 8'h42);
  assign is_br    = (op[7:3] == 5'b01010) && (op[2:0] < 3'd6);
  assign is_jmp   = (op == 8'h58);
  assign is_halt  = (op == 8'h01);
  assign legal    = is_pushc | is_load | is_store | is_pb | is_ps | is_alu2 |
                    is_neg | is_br | is_jmp | is_halt;
  assign pushes   = is_pushc | is_load | is_pb | is_ps;

  assign len  = is_pb ? 2'd2 : (is_ps | is_br | is_jmp) ? 2'd3 : 2'd1;
  assign need = (is_alu2 | is_br) ? 2'd2 : (is_store | is_neg) ? 2'd1 : 2'd0;

  assign exec_now = !halted && ((st == S_OP && len == 2'd1) ||
                                (st == S_B1 && len == 2'd2) ||
                                (st == S_B2));
  assign under = sp < SPW'(need);
  assign over  = pushes && (sp == SPW'(DEPTH));
  assign bad   = !legal || under || over;

  always_comb begin
    push_val = W'(op[2:0]) - W'(1);
    if (is_load)    push_val = loc[op[2:0]];
    else if (is_pb) push_val = {{(W-8){imem_data[7]}}, imem_data};
    else if (is_ps) push_val = {{(W-16){imm16[15]}}, imm16};
  end

  always_comb begin
    case (op[1:0])
      2'd0:    alu_res = b + a;
      2'd1:    alu_res = b - a;
      default: alu_res = b * a;
    endcase
  end

  always_comb begin
    case (op[2:0])
      3'd0:    taken = (b == a);
      3'd1:    taken = (b != a);
      3'd2:    taken = ($signed(b) <  $signed(a));
      3'd3:    taken = ($signed(b) >  $signed(a));
      3'd4:    taken = ($signed(b) <= $signed(a));
      default: taken = ($signed(b) >= $signed(a));
    endcase
  end

  assign imem_addr = (st == S_OP) ? pc : (st == S_B1) ? pc + PCW'(1) : pc + PCW'(2);
  assign tos = (sp == '0) ? '0 : a;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= '0;
      sp     <= '0;
      st     <= S_OP;
      op_q   <= '0;
      hi_q   <= '0;
      halted <= 1'b0;
      fault  <= 1'b0;
      for (int i = 0; i < NLOC; i++) loc[i] <= '0;
    end else if (!halted) begin
      if (st == S_OP) op_q <= imem_data;
      if (st == S_B1) hi_q <= imem_data;
      if (!exec_now) begin
        st <= (st == S_OP) ? S_B1 : S_B2;
      end else begin
        st <= S_OP;
        if (bad) begin
          fault  <= 1'b1;
          halted <= 1'b1;
        end else if (is_halt) begin
          halted <= 1'b1;
        end else begin
          pc <= pc + PCW'(len);
          if (pushes) begin
            stk[pidx] <= push_val;
            sp <= sp + SPW'(1);
          end
          if (is_store) begin
            loc[op[2:0]] <= a;
            sp <= sp - SPW'(1);
          end
          if (is_alu2) begin
            stk[nidx] <= alu_res;
            sp <= sp - SPW'(1);
          end
          if (is_neg) stk[tidx] <= '0 - a;
          if (is_br) begin
            sp <= sp - SPW'(2);
            if (taken) pc <= pc + PCW'(signed'(imm16));
          end
          if (is_jmp) pc <= pc + PCW'(signed'(imm16));
        end
      end
    end
  end

  assert_sp_bound_R9: assert property (@(posedge clk) disable iff (rst)
    sp <= SPW'(DEPTH));
  assert_fault_halts_R13: assert property (@(posedge clk) disable iff (rst)
    fault |-> halted);
  assert_frozen_R13: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc) && $stable(sp) && $stable(fault));
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    (exec_now && over) |=> fault && $stable(sp) && $stable(pc));
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    (exec_now && under) |=> fault && $stable(sp) && $stable(pc));
  assert_const_push_R2: assert property (@(posedge clk) disable iff (rst)
    (exec_now && is_pushc && !over) |=>
      (tos == W'($past(op[2:0])) - W'(1)) && (sp == $past(sp) + SPW'(1)));
  assert_branch_pops_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_now && is_br && !under) |=> sp == $past(sp) - SPW'(2));
endmodule

// File: tb/sim_stack_bc_core.sv
module sim_stack_bc_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0]  imem_addr, pc;
  logic [7:0]  imem_data;
  logic [31:0] tos;
  logic halted, fault;
  logic [7:0] mem [1024];
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign imem_data = mem[imem_addr];

  stack_bc_core u0 (.clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
                    .pc(pc), .tos(tos), .halted(halted), .fault(fault));

  typedef struct packed {
    logic [63:0] prog;
    logic [31:0] tos;
    logic [9:0]  pc;
    logic        flt;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [17] = '{
    '{64'h1001010101010101, 32'hFFFFFFFF, 10'd1, 1'b0, 8'd2},  // R2 push -1
    '{64'h1601010101010101, 32'd5,        10'd1, 1'b0, 8'd2},  // R2 push 5
    '{64'h1513410101010101, 32'd2,        10'd3, 1'b0, 8'd5},  // R5 4-2
    '{64'h1315410101010101, 32'hFFFFFFFE, 10'd3, 1'b0, 8'd5},  // R5 2-4
    '{64'h3080010101010101, 32'hFFFFFF80, 10'd2, 1'b0, 8'd4},  // R4 byte
    '{64'h3181230101010101, 32'hFFFF8123, 10'd3, 1'b0, 8'd4},  // R4 short
    '{64'h3112343010430101, 32'h00012340, 10'd6, 1'b0, 8'd5},  // R5 mul
    '{64'h3007420101010101, 32'hFFFFFFF9, 10'd3, 1'b0, 8'd6},  // R6 neg
    '{64'h152B231440010101, 32'd7,        10'd5, 1'b0, 8'd3},  // R3 store/load
    '{64'h1313500004160101, 32'd0,        10'd6, 1'b0, 8'd7},  // R7 eq taken
    '{64'h1312520004160101, 32'd5,        10'd6, 1'b0, 8'd7},  // R7 lt not taken
    '{64'h1313510004160101, 32'd5,        10'd6, 1'b0, 8'd7},  // R7 ne not taken
    '{64'h1011540004160101, 32'd0,        10'd6, 1'b0, 8'd7},  // R7 le signed taken
    '{64'h1110530004160101, 32'd0,        10'd6, 1'b0, 8'd7},  // R7 gt signed taken
    '{64'h5800041601010101, 32'd0,        10'd4, 1'b0, 8'd8},  // R8 jump
    '{64'h1417010101010101, 32'd3,        10'd1, 1'b1, 8'd11}, // R11 unknown
    '{64'h4001010101010101, 32'd0,        10'd0, 1'b1, 8'd10}  // R10 underflow
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = 8'h01;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 2000; i++) begin
      if (halted) break;
      @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    clear_mem();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pc", 32'(pc), 32'd0);
    chk("R1 tos", tos, 32'd0);
    chk("R1 flags", {30'd0, halted, fault}, 32'd0);

    foreach (VECS[k]) begin
      clear_mem();
      for (int j = 0; j < 8; j++) mem[j] = VECS[k].prog[63-8*j -: 8];
      do_reset();
      run_to_halt();
      chk($sformatf("R%0d vec%0d tos", VECS[k].req, k), tos, VECS[k].tos);
      chk($sformatf("R%0d vec%0d pc", VECS[k].req, k), 32'(pc), 32'(VECS[k].pc));
      chk($sformatf("R%0d vec%0d fault", VECS[k].req, k), 32'(fault), 32'(VECS[k].flt));
    end

    // R12: halt opcode stops without fault and holds pc
    clear_mem();
    mem[0] = 8'h15;
    do_reset();
    run_to_halt();
    repeat (3) @(negedge clk);
    chk("R12 pc", 32'(pc), 32'd1);
    chk("R12 flags", {30'd0, halted, fault}, 32'd2);

    // R3: locals read zero after reset
    clear_mem();
    mem[0] = 8'h27; mem[1] = 8'h12; mem[2] = 8'h40;
    do_reset();
    run_to_halt();
    chk("R3 reset local", tos, 32'd1);

    // R10: store on empty stack
    clear_mem();
    mem[0] = 8'h28;
    do_reset();
    run_to_halt();
    chk("R10 store empty", {31'd0, fault}, 32'd1);

    // R9: sixteen pushes fit, the seventeenth faults
    clear_mem();
    for (int i = 0; i < 17; i++) mem[i] = 8'h12;
    do_reset();
    run_to_halt();
    chk("R9 pc", 32'(pc), 32'd16);
    chk("R9 tos", tos, 32'd1);
    chk("R9 fault", {31'd0, fault}, 32'd1);
    // R13: frozen while halted
    repeat (5) @(negedge clk);
    chk("R13 pc held", 32'(pc), 32'd16);
    chk("R13 flags held", {30'd0, halted, fault}, 32'd3);
    rst = 1'b1;
    @(negedge clk);
    chk("R13 reset clears", {20'd0, pc, halted, fault}, 32'd0);

    // R7/R8: backward branch loop counting local0 up to 5
    clear_mem();
    mem[0] = 8'h12; mem[1] = 8'h20; mem[2] = 8'h40; mem[3] = 8'h28;
    mem[4] = 8'h20; mem[5] = 8'h30; mem[6] = 8'h05;
    mem[7] = 8'h52; mem[8] = 8'hFF; mem[9] = 8'hF9;
    mem[10] = 8'h20;
    do_reset();
    run_to_halt();
    chk("R7 loop tos", tos, 32'd5);
    chk("R7 loop pc", 32'(pc), 32'd11);
    chk("R7 loop fault", {31'd0, fault}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule